// File: doc/BRIEF.md
# Stall-Driven Hardware Thread Scheduler

This block is the issue controller of a multithreaded SIMD shader core. It keeps four hardware thread contexts on chip, and each context has its own program counter and its own state: ready, running or stalled. Every clock the block issues at most one vector instruction, taken from the single running thread, together with that thread's program counter. The decoder tells the block when the instruction being issued is a texture fetch. In that case the running thread becomes stalled, and on the following clock another ready thread takes over, so no issue slot is lost. A stalled thread becomes ready again when the texture unit returns a result tagged with that thread's number.

The scheduler switches only on a stall event. A thread keeps issuing until it blocks. When a new thread must be chosen, the candidates are searched cyclically, starting from the thread after the one that last ran, and the first ready thread found wins. If no thread is ready, the block reports idle and issues nothing. Each cycle it checks again, and the first thread that becomes ready issues on the next clock.

The block also places each thread's four logical vector registers in a private slice of a shared 16-entry register file. It counts issued cycles and idle cycles, so that ALU utilization can be measured.

Top module: `thread_issue_sched`

## Requirements
- R1: After reset, thread 0 is running with program counter 0. Threads 1 to 3 are ready with program counter 0. Both cycle counters read 0.
- R2: In a cycle where a thread is running, issue_valid is 1, issue_tid is the running thread's number and issue_pc is that thread's program counter. The program counter advances by one for each instruction issued. The running thread keeps issuing until it stalls.
- R3: When issue_tex is 1 in an issue cycle, the issuing thread is stalled from the next cycle on. If any other thread is ready in that cycle, issue_valid stays 1 in the next cycle and a different thread issues.
- R4: When the running thread stalls, the next thread is the first ready one found in the order tid+1, tid+2, tid+3 (modulo 4).
- R5: A return (tex_ret_valid=1 with thread number tex_ret_tid) for a stalled thread makes that thread ready. In that same cycle the thread can already be chosen, and it then issues in the next cycle.
- R6: While no thread is running, idle is 1 and issue_valid is 0. In every such cycle a cyclic search for a ready thread starts after the last thread that ran, and that last thread itself is included as the final candidate. A thread found this way issues in the next cycle.
- R7: A return for a thread that is not stalled drives ret_err to 1 in the same cycle and changes no thread state.
- R8: When lreg_we is 1 in an issue cycle and lreg_idx is below 4, preg_we is 1 and preg_idx equals issue_tid*4 + lreg_idx.
- R9: When lreg_we is 1 in an issue cycle and lreg_idx is 4 or above, reg_err is 1 and preg_we is 0.
- R10: issued_cnt counts issue cycles and idle_cnt counts idle cycles. Each count shows one cycle after the cycle it counts. With four threads, a texture fetch after every 20 instructions and a return 50 cycles after each fetch:
  - no cycle is idle;
  - thread 0 issues again, with program counter 20, in cycle 80.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_tex | input | 1 | The instruction issued this cycle is a texture fetch |
| tex_ret_valid | input | 1 | A texture result returns this cycle |
| tex_ret_tid | input | 2 | Thread number of the returning result |
| lreg_we | input | 1 | The issued instruction writes a logical register |
| lreg_idx | input | 4 | Logical register index of the write |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_tid | output | 2 | Thread number of the issued instruction |
| issue_pc | output | 16 | Program counter of the issued instruction |
| idle | output | 1 | No thread is running this cycle |
| preg_we | output | 1 | Physical register write enable |
| preg_idx | output | 4 | Physical register index |
| reg_err | output | 1 | Logical register index is out of range |
| ret_err | output | 1 | A return arrived for a thread that is not stalled |
| issued_cnt | output | 32 | Number of issue cycles so far |
| idle_cnt | output | 32 | Number of idle cycles so far |

## Verification
issue_valid, issue_tid, issue_pc, idle and the register outputs are combinational from the state registers and the inputs of the current cycle. ret_err is also decided in the cycle its input arrives. A stall, a return or a thread pick changes the state one clock later, and the counters lag the cycle they count by one clock. The bench drives inputs at the falling edge and compares every output one nanosecond later, in the same cycle. Its reference model then advances by exactly one clock, so each state effect is checked in the cycle after its stimulus. The fixed points of the 20-instruction, 50-cycle workload are checked in the cycles given by the requirements: the switch to thread 1 in cycle 20, thread 0 with program counter 20 in cycle 80, and both counters in cycle 400.

// File: rtl/sched_pkg.sv
package sched_pkg;
  localparam int NUM_THR      = 4;
  localparam int TID_W        = $clog2(NUM_THR);
  localparam int REGS_PER_THR = 4;
  localparam int PREG_W       = $clog2(NUM_THR * REGS_PER_THR);

  typedef enum logic [1:0] {
    TS_READY = 2'd0,
    TS_RUN   = 2'd1,
    TS_STALL = 2'd2
  } thr_state_e;

  typedef struct packed {
    logic             found;
    logic [TID_W-1:0] tid;
  } pick_t;

  // Nearest candidate after base, cyclically; base itself is the last candidate.
  function automatic pick_t cyclic_pick(input logic [NUM_THR-1:0] cand,
                                        input logic [TID_W-1:0]   base);
    pick_t r;
    int    j;
    r = '0;
    for (int k = NUM_THR; k >= 1; k--) begin
      j = (int'(base) + k) % NUM_THR;
      if (cand[j]) begin
        r.found = 1'b1;
        r.tid   = TID_W'(j);
      end
    end
    return r;
  endfunction

  function automatic logic [PREG_W-1:0] phys_reg(input int tid, input int lidx);
    return PREG_W'(tid * REGS_PER_THR + lidx);
  endfunction

  function automatic logic lidx_ok(input int lidx);
    return lidx < REGS_PER_THR;
  endfunction
endpackage

// File: rtl/thread_ctx.sv
module thread_ctx
  import sched_pkg::*;
#(
  parameter int PC_W      = 16,
  parameter bit START_RUN = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic            issue,
  input  logic            stall,
  input  logic            ret_hit,
  output thr_state_e      state,
  output logic [PC_W-1:0] pc,
  output logic            ready_now
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= START_RUN ? TS_RUN : TS_READY;
      pc    <= '0;
    end else begin
      if (issue) pc <= pc + 1'b1;
      if (stall)                              state <= TS_STALL;
      else if (go)                            state <= TS_RUN;
      else if (state == TS_STALL && ret_hit)  state <= TS_READY;
    end
  end

  assign ready_now = (state == TS_READY) || (state == TS_STALL && ret_hit);
endmodule

// File: rtl/switch_pick.sv
module switch_pick
  import sched_pkg::*;
(
  input  logic [NUM_THR-1:0] ready_now,
  input  logic [TID_W-1:0]   base_tid,
  input  logic               run_valid,
  input  logic               stall,
  output logic               need_pick,
  output pick_t              sel
);
  always_comb begin
    need_pick = !run_valid || stall;
    sel       = cyclic_pick(ready_now, base_tid);
  end
endmodule

// File: rtl/reg_xlate.sv
module reg_xlate
  import sched_pkg::*;
#(
  parameter int LIDX_W = 4
) (
  input  logic              active,
  input  logic [TID_W-1:0]  tid,
  input  logic              we,
  input  logic [LIDX_W-1:0] lidx,
  output logic              preg_we,
  output logic [PREG_W-1:0] preg_idx,
  output logic              reg_err
);
  logic in_range;
  always_comb begin
    in_range = lidx_ok(int'(lidx));
    preg_idx = phys_reg(int'(tid), in_range ? int'(lidx) : 0);
    preg_we  = active && we && in_range;
    reg_err  = active && we && !in_range;
  end
endmodule

// File: rtl/issue_counters.sv
module issue_counters #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  output logic [CNT_W-1:0] issued_cnt,
  output logic [CNT_W-1:0] idle_cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      issued_cnt <= '0;
      idle_cnt   <= '0;
    end else if (busy) begin
      issued_cnt <= issued_cnt + 1'b1;
    end else begin
      idle_cnt   <= idle_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/thread_issue_sched.sv
module thread_issue_sched
  import sched_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int CNT_W  = 32,
  parameter int LIDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_tex,
  input  logic              tex_ret_valid,
  input  logic [TID_W-1:0]  tex_ret_tid,
  input  logic              lreg_we,
  input  logic [LIDX_W-1:0] lreg_idx,
  output logic              issue_valid,
  output logic [TID_W-1:0]  issue_tid,
  output logic [PC_W-1:0]   issue_pc,
  output logic              idle,
  output logic              preg_we,
  output logic [PREG_W-1:0] preg_idx,
  output logic              reg_err,
  output logic              ret_err,
  output logic [CNT_W-1:0]  issued_cnt,
  output logic [CNT_W-1:0]  idle_cnt
);
  logic             run_valid;
  logic [TID_W-1:0] run_tid;

  thr_state_e        thr_state [NUM_THR];
  logic [PC_W-1:0]   thr_pc    [NUM_THR];
  logic [NUM_THR-1:0] ready_now_vec, stalled_vec, running_vec, ret_hit_vec, go_vec;

  // named events for the checker
  logic  stall_evt, switch_evt, ret_accept, need_pick;
  pick_t sel;

  assign stall_evt  = run_valid && issue_tex;
  assign ret_accept = tex_ret_valid && stalled_vec[tex_ret_tid];
  assign switch_evt = need_pick && sel.found;

  switch_pick u_pick (
    .ready_now (ready_now_vec),
    .base_tid  (run_tid),
    .run_valid (run_valid),
    .stall     (stall_evt),
    .need_pick (need_pick),
    .sel       (sel)
  );

  for (genvar i = 0; i < NUM_THR; i++) begin : g_thr
    assign ret_hit_vec[i] = tex_ret_valid && (tex_ret_tid == TID_W'(i));
    assign go_vec[i]      = switch_evt && (sel.tid == TID_W'(i));
    assign stalled_vec[i] = (thr_state[i] == TS_STALL);
    assign running_vec[i] = (thr_state[i] == TS_RUN);

    thread_ctx #(.PC_W(PC_W), .START_RUN(i == 0)) u_ctx (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (go_vec[i]),
      .issue     (run_valid && run_tid == TID_W'(i)),
      .stall     (stall_evt && run_tid == TID_W'(i)),
      .ret_hit   (ret_hit_vec[i]),
      .state     (thr_state[i]),
      .pc        (thr_pc[i]),
      .ready_now (ready_now_vec[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_valid <= 1'b1;
      run_tid   <= '0;
    end else if (need_pick) begin
      run_valid <= sel.found;
      if (sel.found) run_tid <= sel.tid;
    end
  end

  assign issue_valid = run_valid;
  assign issue_tid   = run_tid;
  assign issue_pc    = thr_pc[run_tid];
  assign idle        = !run_valid;
  assign ret_err     = tex_ret_valid && !stalled_vec[tex_ret_tid];

  reg_xlate #(.LIDX_W(LIDX_W)) u_xlate (
    .active   (run_valid),
    .tid      (run_tid),
    .we       (lreg_we),
    .lidx     (lreg_idx),
    .preg_we  (preg_we),
    .preg_idx (preg_idx),
    .reg_err  (reg_err)
  );

  issue_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (run_valid),
    .issued_cnt (issued_cnt),
    .idle_cnt   (idle_cnt)
  );
endmodule

// File: rtl/sched_chk.sv
module sched_chk
  import sched_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               issue_valid,
  input logic [TID_W-1:0]   issue_tid,
  input logic               idle,
  input logic               preg_we,
  input logic [PREG_W-1:0]  preg_idx,
  input logic               reg_err,
  input logic               ret_err,
  input logic [TID_W-1:0]   tex_ret_tid,
  input logic [CNT_W-1:0]   issued_cnt,
  input logic [CNT_W-1:0]   idle_cnt,
  input logic [NUM_THR-1:0] running_vec,
  input logic [NUM_THR-1:0] stalled_vec,
  input logic [NUM_THR-1:0] ready_now_vec,
  input logic               stall_evt,
  input logic               ret_accept
);
  // R2
  one_runner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(running_vec));
  // R2
  issue_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> running_vec[issue_tid]);
  // R3
  stall_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_evt |=> stalled_vec[$past(issue_tid)]);
  // R3
  switch_away_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_evt && (|ready_now_vec)) |=> (issue_valid && issue_tid != $past(issue_tid)));
  // R5
  wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_accept |=> !stalled_vec[$past(tex_ret_tid)]);
  // R6
  idle_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && (|ready_now_vec)) |=> issue_valid);
  // R7
  ret_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_err && !stall_evt) |=> (stalled_vec == $past(stalled_vec)));
  // R8
  preg_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    preg_we |-> (int'(preg_idx) / REGS_PER_THR == int'(issue_tid)));
  // R9
  reg_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_err |-> !preg_we);
  // R10
  issued_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |=> issued_cnt == $past(issued_cnt) + 1'b1);
  // R10
  idle_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> idle_cnt == $past(idle_cnt) + 1'b1);
endmodule

bind thread_issue_sched sched_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .issue_valid   (issue_valid),
  .issue_tid     (issue_tid),
  .idle          (idle),
  .preg_we       (preg_we),
  .preg_idx      (preg_idx),
  .reg_err       (reg_err),
  .ret_err       (ret_err),
  .tex_ret_tid   (tex_ret_tid),
  .issued_cnt    (issued_cnt),
  .idle_cnt      (idle_cnt),
  .running_vec   (running_vec),
  .stalled_vec   (stalled_vec),
  .ready_now_vec (ready_now_vec),
  .stall_evt     (stall_evt),
  .ret_accept    (ret_accept)
);

// File: tb/thread_issue_sched_bench.sv
`timescale 1ns/1ps
module thread_issue_sched_bench;
  localparam int PC_W = 16, CNT_W = 32, LIDX_W = 4, NT = 4, LAST_CYC = 1700;

  logic clk = 1'b0, rst_n = 1'b0;
  logic issue_tex = 0, tex_ret_valid = 0, lreg_we = 0;
  logic [1:0] tex_ret_tid = '0;
  logic [LIDX_W-1:0] lreg_idx = '0;
  logic issue_valid, idle, preg_we, reg_err, ret_err;
  logic [1:0] issue_tid;
  logic [PC_W-1:0] issue_pc;
  logic [3:0] preg_idx;
  logic [CNT_W-1:0] issued_cnt, idle_cnt;

  always #4 clk = ~clk;

  thread_issue_sched #(.PC_W(PC_W), .CNT_W(CNT_W), .LIDX_W(LIDX_W)) u_thread_issue_sched (
    .clk(clk), .rst_n(rst_n), .issue_tex(issue_tex), .tex_ret_valid(tex_ret_valid),
    .tex_ret_tid(tex_ret_tid), .lreg_we(lreg_we), .lreg_idx(lreg_idx),
    .issue_valid(issue_valid), .issue_tid(issue_tid), .issue_pc(issue_pc), .idle(idle),
    .preg_we(preg_we), .preg_idx(preg_idx), .reg_err(reg_err), .ret_err(ret_err),
    .issued_cnt(issued_cnt), .idle_cnt(idle_cnt));

  // reference model: 0 ready, 1 running, 2 stalled
  int m_st [NT];
  int m_pc [NT];
  int due  [NT];
  int m_run, m_issued, m_idle, cyc, checks, fails;
  bit m_active, prev_stall, prev_wake, done;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
    end
  endtask

  function automatic int latency(input int c);
    if (c < 400) return 50;
    if (c < 800) return 90;
    if (c < 1400) return 1 + (c * 7) % 50;
    return 1;
  endfunction

  task automatic step();
    bit rv, tex, we, rn [NT], stall, found;
    int rt, li, j;
    string ttag;
    // drive inputs
    tex = m_active && (m_pc[m_run] % 20 == 19);
    rv = 0; rt = 0;
    for (int t = NT - 1; t >= 0; t--)
      if (due[t] >= 0 && due[t] <= cyc) begin rv = 1; rt = t; end
    if (rv) due[rt] = -1;
    else if (cyc >= 1000 && cyc < 1600 && cyc % 13 == 0) begin
      for (int k = NT - 1; k >= 0; k--)
        if (m_st[(cyc + k) % NT] != 2) begin rv = 1; rt = (cyc + k) % NT; end
    end
    we = ($urandom % 4) != 0;
    li = ($urandom % 2) ? int'($urandom % 4) : int'($urandom % 16);
    issue_tex = tex; tex_ret_valid = rv; tex_ret_tid = 2'(rt);
    lreg_we = we; lreg_idx = LIDX_W'(li);
    #1;
    // compare
    ttag = (cyc == 0) ? "R1" : (prev_stall ? "R4" : (prev_wake ? "R5" : "R2"));
    chk(prev_stall ? "R3" : "R2", "issue_valid", issue_valid, m_active);
    if (m_active) begin
      chk(ttag, "issue_tid", issue_tid, m_run);
      chk(cyc == 0 ? "R1" : "R2", "issue_pc", issue_pc, m_pc[m_run]);
    end
    chk("R6", "idle", idle, !m_active);
    chk("R7", "ret_err", ret_err, rv && m_st[rt] != 2);
    chk("R8", "preg_we", preg_we, m_active && we && li < 4);
    if (m_active && we && li < 4) chk("R8", "preg_idx", preg_idx, m_run * 4 + li);
    chk("R9", "reg_err", reg_err, m_active && we && li >= 4);
    chk(cyc == 0 ? "R1" : "R10", "issued_cnt", issued_cnt, m_issued);
    chk(cyc == 0 ? "R1" : "R10", "idle_cnt", idle_cnt, m_idle);
    if (cyc == 20) chk("R4", "tid after first stall", issue_tid, 1);
    if (cyc == 80) begin
      chk("R10", "resume tid", issue_tid, 0);
      chk("R10", "resume pc", issue_pc, 20);
    end
    if (cyc == 400) begin
      chk("R10", "utilization issued", issued_cnt, 400);
      chk("R10", "utilization idle", idle_cnt, 0);
    end
    if (cyc == 800) chk("R6", "idle seen in long latency", idle_cnt != 0, 1);
    // advance model
    for (int t = 0; t < NT; t++) rn[t] = (m_st[t] == 0) || (m_st[t] == 2 && rv && rt == t);
    prev_wake = rv && m_st[rt] == 2 && !m_active;
    stall = m_active && tex;
    if (m_active) begin m_pc[m_run]++; m_issued++; end else m_idle++;
    if (rv && m_st[rt] == 2) m_st[rt] = 0;
    if (stall) begin m_st[m_run] = 2; due[m_run] = cyc + latency(cyc); end
    prev_stall = stall;
    if (!m_active || stall) begin
      found = 0; j = 0;
      for (int k = 1; k <= NT; k++)
        if (!found && rn[(m_run + k) % NT]) begin found = 1; j = (m_run + k) % NT; end
      if (found) begin m_st[j] = 1; m_run = j; m_active = 1; end
      else m_active = 0;
    end
    @(posedge clk);
    @(negedge clk);
    cyc++;
  endtask

  initial begin
    for (int t = 0; t < NT; t++) begin m_st[t] = (t == 0) ? 1 : 0; m_pc[t] = 0; due[t] = -1; end
    m_run = 0; m_active = 1; m_issued = 0; m_idle = 0; cyc = 0;
    checks = 0; fails = 0; prev_stall = 0; prev_wake = 0; done = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    while (cyc < LAST_CYC) step();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog cycle %0d: actual 0 expected 1", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule